// File: doc/BRIEF.md
# Receive Exact-Address Filter Table

This block holds a small table of station addresses that a receive path uses to accept frames addressed to it. Software fills each slot through a 32-bit register port, two registers per slot. When the receive path presents the 48-bit destination address of an incoming frame together with a strobe, the block compares that address against every slot whose valid flag is set. One cycle later it reports whether any slot matched, the number of the matching slot, and a pool number stored with that slot.

A clear command wipes every slot except slot 0, which keeps the primary station address. A separate qualifier takes a candidate station address and, one cycle later, says whether it can serve as an individual (unicast) address.

Top module: `rx_addr_filter`

## Requirements
- R1: After synchronous reset every register of every slot reads as zero, and `hit_valid`, `hit` and `cand_done` are low.
- R2: `cfg_addr[0]` selects the low (0) or high (1) register and `cfg_addr[4:1]` selects the slot; a write with `cfg_we` stores all 32 bits of `cfg_wdata`, and `cfg_rdata` returns the last value written to the register addressed one cycle earlier.
- R3: Address byte k, counted in transmission order, is `da_addr[8k+7:8k]`; the low register holds bytes 0 to 3 with byte 0 in bits 7:0, and the high register holds byte 4 in bits 7:0 and byte 5 in bits 15:8. A slot matches only when all six bytes are equal.
- R4: Bit 31 of the high register is the valid flag; a slot with it clear never matches.
- R5: For each cycle with `da_valid` high, `hit_valid` is high for exactly the next cycle, including on back-to-back strobes; `hit_valid` is never high otherwise.
- R6: When several valid slots match, `hit_index` reports the lowest slot number.
- R7: On a hit, `hit_pool` carries bits 21:18 of the matching slot's high register; on a miss, `hit_index` and `hit_pool` are zero.
- R8: `init_clear` zeroes both registers of slots 1 to 15 and leaves slot 0 unchanged; in the same cycle it overrides a write to slots 1 to 15, while a write to slot 0 still takes effect.
- R9: One cycle after `cand_valid`, `cand_done` is high and `cand_ok` is low if the group bit (`cand_addr[0]`) is set, if all 48 bits are one, or if all 48 bits are zero, and high otherwise.
- R10: A lookup strobed in the same cycle as a register write is compared against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address: slot number and low/high select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after address |
| init_clear | input | 1 | Clear slots 1 to 15 |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| hit_valid | output | 1 | Lookup result valid |
| hit | output | 1 | A valid slot matched |
| hit_index | output | 4 | Lowest matching slot |
| hit_pool | output | 4 | Pool number of the matching slot |
| cand_valid | input | 1 | Candidate address strobe |
| cand_addr | input | 48 | Candidate station address |
| cand_done | output | 1 | Qualifier result valid |
| cand_ok | output | 1 | Candidate is a usable individual address |

## Verification
A corrupted slot shows up at the ports in two ways: the very next read of that register returns a value other than the one written, and the very next lookup of the stored address misses or reports the wrong slot or pool one cycle after its strobe. A broken priority or valid-flag decode is exposed only by lookups that hit several slots or hit disabled slots, so the stimulus deliberately duplicates addresses across slots and toggles the valid flag. Lookup results are queued at strobe time and compared when `hit_valid` rises, so a lost or extra result is seen within one cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int REG_W     = 32;
  localparam int MAC_W     = 48;
  localparam int VALID_BIT = 31;
  localparam int LOW_BYTES = REG_W / 8;

  typedef logic [MAC_W-1:0] mac_t;

  // Usable as an individual address: not group, not broadcast, not zero.
  function automatic logic mac_is_individual(mac_t a);
    return !a[0] && (a != {MAC_W{1'b1}}) && (a != '0);
  endfunction

endpackage

// File: rtl/rxf_entry_table.sv
module rxf_entry_table
  import rxf_pkg::*;
#(
  parameter int N_SLOTS  = 16,
  parameter int ADDR_W   = 5,
  parameter int POOL_LSB = 18,
  parameter int POOL_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [REG_W-1:0]                wdata,
  input  logic                            init_clear,
  output logic [REG_W-1:0]                rdata,
  output logic [N_SLOTS-1:0][MAC_W-1:0]   mac_o,
  output logic [N_SLOTS-1:0]              valid_o,
  output logic [N_SLOTS-1:0][POOL_W-1:0]  pool_o
);

  localparam int IDX_W = ADDR_W - 1;
  localparam int HI_MAC_W = MAC_W - REG_W;

  logic [REG_W-1:0] lo_q [N_SLOTS];
  logic [REG_W-1:0] hi_q [N_SLOTS];
  logic [IDX_W-1:0] slot_sel;

  assign slot_sel = addr[ADDR_W-1:1];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic sel;
    assign sel = we && (slot_sel == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else if (init_clear && (i != 0)) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else if (sel) begin
        if (addr[0]) hi_q[i] <= wdata;
        else         lo_q[i] <= wdata;
      end
    end

    assign mac_o[i]   = {hi_q[i][HI_MAC_W-1:0], lo_q[i]};
    assign valid_o[i] = hi_q[i][VALID_BIT];
    assign pool_o[i]  = hi_q[i][POOL_LSB +: POOL_W];

    if (i == 0) begin : g_keep
      AST_INIT_KEEPS_SLOT0: assert property (@(posedge clk) disable iff (rst)
        (init_clear && !sel) |=> ($stable(lo_q[i]) && $stable(hi_q[i]))); // R8
    end else begin : g_clr
      AST_INIT_CLEARS_SLOT: assert property (@(posedge clk) disable iff (rst)
        init_clear |=> (lo_q[i] == '0 && hi_q[i] == '0)); // R8
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= addr[0] ? hi_q[slot_sel] : lo_q[slot_sel];
  end

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (we && !init_clear) |=> (addr[0] ? hi_q[$past(slot_sel)] : lo_q[$past(slot_sel)]) == $past(wdata)); // R2

endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int POOL_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_SLOTS-1:0][MAC_W-1:0]   mac_i,
  input  logic [N_SLOTS-1:0]              valid_i,
  input  logic [N_SLOTS-1:0][POOL_W-1:0]  pool_i,
  input  logic                            da_valid,
  input  mac_t                            da_addr,
  output logic                            hit_valid,
  output logic                            hit,
  output logic [$clog2(N_SLOTS)-1:0]      hit_index,
  output logic [POOL_W-1:0]               hit_pool
);

  localparam int IDX_W = $clog2(N_SLOTS);

  logic [N_SLOTS-1:0] match_vec;
  logic               any_d;
  logic [IDX_W-1:0]   idx_d;
  logic [POOL_W-1:0]  pool_d;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_cmp
    assign match_vec[i] = valid_i[i] && (mac_i[i] == da_addr);
  end

  // Walk downward so the lowest matching slot is the last one assigned.
  always_comb begin
    any_d = 1'b0;
    idx_d = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_d = 1'b1;
        idx_d = IDX_W'(i);
      end
    end
    pool_d = any_d ? pool_i[idx_d] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      hit_index <= '0;
      hit_pool  <= '0;
    end else begin
      hit_valid <= da_valid;
      hit       <= da_valid && any_d;
      hit_index <= da_valid ? idx_d  : '0;
      hit_pool  <= da_valid ? pool_d : '0;
    end
  end

  AST_RESULT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
    da_valid |=> hit_valid); // R5
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
    !da_valid |=> !hit_valid); // R5
  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    hit |-> hit_valid); // R5
  AST_MISS_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hit_valid && !hit) |-> (hit_index == '0 && hit_pool == '0)); // R7
  AST_INVALID_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
    (da_valid && valid_i == '0) |=> !hit); // R4

endmodule

// File: rtl/rxf_addr_qualify.sv
module rxf_addr_qualify
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cand_valid,
  input  mac_t cand_addr,
  output logic cand_done,
  output logic cand_ok
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_done <= 1'b0;
      cand_ok   <= 1'b0;
    end else begin
      cand_done <= cand_valid;
      cand_ok   <= cand_valid && mac_is_individual(cand_addr);
    end
  end

  AST_CAND_LATENCY: assert property (@(posedge clk) disable iff (rst)
    cand_valid |=> cand_done); // R9
  AST_GROUP_REJECTED: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && cand_addr[0]) |=> !cand_ok); // R9
  AST_OK_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    cand_ok |-> cand_done); // R9

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int POOL_LSB    = 18,
  parameter int POOL_W      = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [$clog2(NUM_ENTRIES):0]    cfg_addr,
  input  logic [31:0]                     cfg_wdata,
  output logic [31:0]                     cfg_rdata,
  input  logic                            init_clear,
  input  logic                            da_valid,
  input  logic [47:0]                     da_addr,
  output logic                            hit_valid,
  output logic                            hit,
  output logic [$clog2(NUM_ENTRIES)-1:0]  hit_index,
  output logic [POOL_W-1:0]               hit_pool,
  input  logic                            cand_valid,
  input  logic [47:0]                     cand_addr,
  output logic                            cand_done,
  output logic                            cand_ok
);

  localparam int ADDR_W = $clog2(NUM_ENTRIES) + 1;

  logic [NUM_ENTRIES-1:0][MAC_W-1:0]  tbl_mac;
  logic [NUM_ENTRIES-1:0]             tbl_valid;
  logic [NUM_ENTRIES-1:0][POOL_W-1:0] tbl_pool;

  rxf_entry_table #(
    .N_SLOTS (NUM_ENTRIES),
    .ADDR_W  (ADDR_W),
    .POOL_LSB(POOL_LSB),
    .POOL_W  (POOL_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .init_clear(init_clear),
    .rdata     (cfg_rdata),
    .mac_o     (tbl_mac),
    .valid_o   (tbl_valid),
    .pool_o    (tbl_pool)
  );

  rxf_match #(
    .N_SLOTS(NUM_ENTRIES),
    .POOL_W (POOL_W)
  ) u_match (
    .clk      (clk),
    .rst      (rst),
    .mac_i    (tbl_mac),
    .valid_i  (tbl_valid),
    .pool_i   (tbl_pool),
    .da_valid (da_valid),
    .da_addr  (da_addr),
    .hit_valid(hit_valid),
    .hit      (hit),
    .hit_index(hit_index),
    .hit_pool (hit_pool)
  );

  rxf_addr_qualify u_qual (
    .clk       (clk),
    .rst       (rst),
    .cand_valid(cand_valid),
    .cand_addr (cand_addr),
    .cand_done (cand_done),
    .cand_ok   (cand_ok)
  );

endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        init_clear = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        hit_valid, hit;
  logic [3:0]  hit_index, hit_pool;
  logic        cand_valid = 1'b0;
  logic [47:0] cand_addr = '0;
  logic        cand_done, cand_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u_rx_addr_filter (.*);

  typedef struct {
    logic       hit;
    logic [3:0] idx;
    logic [3:0] pool;
    string      tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  int tests = 0;
  int fails = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hi_word(logic [47:0] mac, logic [3:0] pool, logic v);
    return {v, 9'd0, pool, 2'd0, mac[47:32]};
  endfunction

  function automatic exp_t lookup(logic [47:0] mac, string tag);
    exp_t e;
    e.hit = 1'b0; e.idx = '0; e.pool = '0; e.tag = tag;
    for (int i = N - 1; i >= 0; i--)
      if (m_hi[i][31] && m_lo[i] == mac[31:0] && m_hi[i][15:0] == mac[47:32]) begin
        e.hit = 1'b1; e.idx = 4'(i); e.pool = m_hi[i][21:18];
      end
    return e;
  endfunction

  task automatic wr(int slot, logic hi, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {4'(slot), hi}; cfg_wdata = d;
    if (hi) m_hi[slot] = d; else m_lo[slot] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(int slot, logic hi, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_addr = {4'(slot), hi};
    @(negedge clk);
    check(tag, cfg_rdata, exp);
  endtask

  task automatic strobe(logic [47:0] mac, string tag);
    @(negedge clk);
    da_valid = 1'b1; da_addr = mac;
    exp_q.push_back(lookup(mac, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    da_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic init_with_write(int slot, logic hi, logic [31:0] d);
    @(negedge clk);
    init_clear = 1'b1; cfg_we = 1'b1; cfg_addr = {4'(slot), hi}; cfg_wdata = d;
    if (slot == 0) begin
      if (hi) m_hi[0] = d; else m_lo[0] = d;
    end
    for (int i = 1; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    @(negedge clk);
    init_clear = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cand(logic [47:0] mac, logic exp_ok, string tag);
    @(negedge clk);
    cand_valid = 1'b1; cand_addr = mac;
    @(negedge clk);
    cand_valid = 1'b0;
    check({tag, " done"}, 32'(cand_done), 32'd1);
    check({tag, " ok"}, 32'(cand_ok), 32'(exp_ok));
  endtask

  // Monitor: pops an expected lookup result whenever the design presents one.
  always @(negedge clk) begin
    if (!rst && hit_valid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R5 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " hit"},   32'(hit),       32'(e.hit));
        check({e.tag, " index"}, 32'(hit_index), 32'(e.idx));
        check({e.tag, " pool"},  32'(hit_pool),  32'(e.pool));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [47:0] MAC_A = 48'hccbbaa211b00;
  localparam logic [47:0] MAC_B = 48'h665544332202;
  localparam logic [47:0] MAC_C = 48'h0a0908070604;

  initial begin
    for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 hit_valid", 32'(hit_valid), 32'd0);
    check("R1 cand_done", 32'(cand_done), 32'd0);
    rd(0, 1'b0, 32'd0, "R1 slot0 low");
    rd(15, 1'b1, 32'd0, "R1 slot15 high");

    // R2: full-width write and readback
    wr(15, 1'b1, 32'h7fffffff);
    wr(9, 1'b0, 32'h12345678);
    rd(15, 1'b1, 32'h7fffffff, "R2 slot15 high");
    rd(9, 1'b0, 32'h12345678, "R2 slot9 low");

    // R3: byte layout and exact match
    wr(0, 1'b0, 32'haa211b00);
    wr(0, 1'b1, 32'h8000ccbb);
    rd(0, 1'b1, 32'h8000ccbb, "R2 slot0 high");
    strobe(MAC_A, "R3 primary match"); idle();
    strobe(48'h001b21aabbcc, "R3 byte swapped miss"); idle();
    strobe(MAC_A ^ 48'h010000000000, "R3 byte5 differs"); idle();

    // R4: valid flag gates matching
    wr(5, 1'b0, MAC_B[31:0]);
    wr(5, 1'b1, hi_word(MAC_B, 4'd9, 1'b0));
    strobe(MAC_B, "R4 invalid slot"); idle();
    wr(5, 1'b1, hi_word(MAC_B, 4'd9, 1'b1));
    strobe(MAC_B, "R4 enabled slot"); idle();

    // R5: back-to-back strobes
    strobe(MAC_A, "R5 b2b first");
    strobe(MAC_B, "R5 b2b second");
    strobe(MAC_C, "R5 b2b third"); idle();

    // R6/R7: duplicates, lowest index and its pool
    wr(7, 1'b0, MAC_C[31:0]);
    wr(7, 1'b1, hi_word(MAC_C, 4'd12, 1'b1));
    wr(3, 1'b0, MAC_C[31:0]);
    wr(3, 1'b1, hi_word(MAC_C, 4'd3, 1'b1));
    strobe(MAC_C, "R6 lowest of two"); idle();
    wr(3, 1'b1, hi_word(MAC_C, 4'd3, 1'b0));
    strobe(MAC_C, "R7 pool of slot7"); idle();

    // R10: strobe in the same cycle as a write sees old contents
    @(negedge clk);
    da_valid = 1'b1; da_addr = MAC_C;
    exp_q.push_back(lookup(MAC_C, "R10 same-cycle write"));
    cfg_we = 1'b1; cfg_addr = {4'd7, 1'b1}; cfg_wdata = hi_word(MAC_A, 4'd1, 1'b1);
    m_hi[7] = hi_word(MAC_A, 4'd1, 1'b1);
    @(negedge clk);
    da_valid = 1'b0; cfg_we = 1'b0;
    strobe(MAC_C, "R10 after write"); idle();

    // R8: clear keeps slot 0, overrides a write elsewhere
    init_with_write(2, 1'b0, 32'hdeadbeef);
    rd(2, 1'b0, 32'd0, "R8 write dropped");
    rd(5, 1'b1, 32'd0, "R8 slot5 cleared");
    rd(15, 1'b1, 32'd0, "R8 slot15 cleared");
    rd(0, 1'b0, 32'haa211b00, "R8 slot0 kept");
    strobe(MAC_B, "R8 cleared miss"); idle();
    strobe(MAC_A, "R8 slot0 still hits"); idle();
    init_with_write(0, 1'b1, hi_word(MAC_A, 4'd6, 1'b1));
    rd(0, 1'b1, hi_word(MAC_A, 4'd6, 1'b1), "R8 slot0 write kept");
    strobe(MAC_A, "R8 new pool"); idle();

    // R9: individual-address qualifier
    cand(MAC_A, 1'b1, "R9 unicast");
    cand(48'h000000000001, 1'b0, "R9 group bit");
    cand(48'hffffffffffff, 1'b0, "R9 broadcast");
    cand(48'h000000000000, 1'b0, "R9 zero");
    cand(48'h000000000002, 1'b1, "R9 low unicast");
    cand(48'hfffffffffffe, 1'b1, "R9 near broadcast");

    repeat (3) @(negedge clk);
    check("R5 results drained", 32'(exp_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule